// File: doc/BRIEF.md
# Chained Ternary Match Table

This block is a small ternary rule table for an ingress packet classifier. Each entry has eight 32-bit data words and eight 32-bit mask words. A host reaches the entries only indirectly. It fills holding registers, then launches a read or write of the entry table, the action RAM or the meter RAM at a chosen address through one access register. The host can also start a table-wide clear.

For a lookup, the block takes two key slices and the ingress port number. Every valid entry is compared against the key slice named by its slice ID. The lowest matching address wins, and its index (the classification ID) and its action word are returned two cycles later. An entry can be chained. A chained entry matches only when its chain field names the entry that won among the unchained slice-0 entries. Two entries together then form one wide rule, for example source and destination halves of a long address tuple. The second half sits at a lower address than the first half so that it takes priority.

Top module: `chain_tcam`

## Requirements
- R1: A key bit is compared only where the entry's mask bit is 1. An entry can match only when data word 0 bits 1:0 equal 2'b11; clearing those bits removes it from every search.
- R2: Among all matching entries the lowest address wins. res_idx_o carries that address and res_action_o carries that entry's action word. When nothing matches, res_miss_o is raised instead of res_hit_o, and res_idx_o and res_action_o are zero. res_hit_o and res_miss_o are never high together.
- R3: A lookup request sampled on rising edge k shows res_valid_o high, with its result, right after edge k+1 and for one cycle; no result appears after edge k.
- R4: Word 7 bits NUM_PORTS-1:0 hold a port bitmap and mask. An entry with a non-zero port mask matches only if the ingress port's bit is set in both. A zero port mask accepts any port. Register 19 holds one lookup enable bit per port; a request from a disabled port produces no result.
- R5: An entry whose data word 6 bits 31:24 are non-zero is chained. Those bits are left out of the compare, and the entry matches only when they equal the lowest-addressed matching unchained slice-0 entry.
- R6: Entry 0 is reserved. Table writes to address 0 are dropped, it never hits, and a chain field of 0 means "not chained".
- R7: Registers 0-7 are the data holding words, 8-15 the mask holding words, 16 the access register, 17 the action holding word, 18 the meter holding word and 19 the port enable. Access register fields: bit 0 start/busy, bit 1 write (1) or read (0), bits 3:2 RAM select (0 table, 1 action, 2 meter), bit 4 clear, bits 15:8 address. Start reads 1 for exactly the cycle after launch. A write copies the holding registers into the selected RAM; a read copies the RAM into them.
- R8: Setting the clear bit zeroes every entry's data and mask, one entry per cycle. The bit reads 1 for NUM_ENTRIES cycles and then clears itself.
- R9: Data word 0 bits 3:2 give the slice ID. ID 0 compares against key slice 0, ID 1 against key slice 1, and IDs 2 and 3 never match.
- R10: Writes to the access register are ignored while an operation or a clear is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 5 | Host register address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, combinational from address |
| lk_valid_i | input | 1 | Lookup request |
| lk_port_i | input | $clog2(NUM_PORTS) | Ingress port of the frame |
| lk_key0_i | input | 224 | Key slice 0, words 0-6 |
| lk_key1_i | input | 224 | Key slice 1, words 0-6 |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | An entry matched |
| res_miss_o | output | 1 | No entry matched |
| res_idx_o | output | $clog2(NUM_ENTRIES) | Winning address (classification ID) |
| res_action_o | output | 32 | Action word of the winning entry |

## Verification
A lookup request is held for one cycle. Its result is due one rising edge after the next one. The bench checks that res_valid_o is still low half a cycle after the sampling edge, and reads the result half a cycle after the following edge. Host operations take effect on the edge after the access-register write edge, so the start bit is read once in the cycle after launch and once in the cycle after that. During a clear, the clear bit is read in each of the NUM_ENTRIES cycles after launch and once more after it should have dropped. All outputs are sampled on falling edges.

// File: rtl/chain_tcam_pkg.sv
package chain_tcam_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int ENTRY_W   = WORD_W * NUM_WORDS;
  localparam int KEY_W     = WORD_W * (NUM_WORDS - 1);
  localparam int CHAIN_W   = 8;
  localparam int CHAIN_LSB = 6 * WORD_W + 24;
  localparam int PORT_LSB  = 7 * WORD_W;
  localparam int NUM_SLICES = 2;

  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] ent_t;

  typedef enum logic [1:0] {
    RAM_TABLE = 2'd0,
    RAM_ACT   = 2'd1,
    RAM_METER = 2'd2,
    RAM_NONE  = 2'd3
  } ram_sel_e;

  localparam logic [4:0] REG_ACC = 5'd16;
  localparam logic [4:0] REG_ACT = 5'd17;
  localparam logic [4:0] REG_MET = 5'd18;
  localparam logic [4:0] REG_PEN = 5'd19;
endpackage

// File: rtl/ctam_host.sv
module ctam_host
  import chain_tcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                reg_we_i,
  input  logic [4:0]                          reg_addr_i,
  input  logic [31:0]                         reg_wdata_i,
  output logic [31:0]                         reg_rdata_o,
  output ent_t [NUM_ENTRIES-1:0]              ent_d_o,
  output ent_t [NUM_ENTRIES-1:0]              ent_m_o,
  output logic [NUM_ENTRIES-1:0][WORD_W-1:0]  act_o,
  output logic [NUM_PORTS-1:0]                port_en_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [7:0] ADDR_LIM = 8'(NUM_ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic start_q, op_q, clr_q;
  ram_sel_e ram_q;
  logic [7:0] addr_q;
  logic [IDX_W-1:0] clr_cnt;
  ent_t hold_d, hold_m;
  logic [WORD_W-1:0] act_hold, met_hold;
  logic [NUM_PORTS-1:0] pen_q;
  ent_t [NUM_ENTRIES-1:0] ent_d, ent_m;
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] act_ram, met_ram;

  logic busy, addr_ok;
  logic [IDX_W-1:0] idx;
  assign busy    = start_q | clr_q;
  assign addr_ok = addr_q < ADDR_LIM;
  assign idx     = addr_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0; op_q <= 1'b0; clr_q <= 1'b0; ram_q <= RAM_TABLE;
      addr_q <= '0; clr_cnt <= '0; hold_d <= '0; hold_m <= '0;
      act_hold <= '0; met_hold <= '0; pen_q <= '0;
      ent_d <= '0; ent_m <= '0; act_ram <= '0; met_ram <= '0;
    end else begin
      if (reg_we_i) begin
        if (reg_addr_i[4:3] == 2'b00) hold_d[reg_addr_i[2:0]] <= reg_wdata_i;
        else if (reg_addr_i[4:3] == 2'b01) hold_m[reg_addr_i[2:0]] <= reg_wdata_i;
        else begin
          case (reg_addr_i)
            REG_ACC: if (!busy) begin
              start_q <= reg_wdata_i[0] & ~reg_wdata_i[4];
              op_q    <= reg_wdata_i[1];
              ram_q   <= ram_sel_e'(reg_wdata_i[3:2]);
              clr_q   <= reg_wdata_i[4];
              addr_q  <= reg_wdata_i[15:8];
            end
            REG_ACT: act_hold <= reg_wdata_i;
            REG_MET: met_hold <= reg_wdata_i;
            REG_PEN: pen_q    <= reg_wdata_i[NUM_PORTS-1:0];
            default: ;
          endcase
        end
      end
      if (start_q) begin
        start_q <= 1'b0;
        if (addr_ok) begin
          case (ram_q)
            RAM_TABLE: if (op_q) begin
              if (idx != '0) begin  // entry 0 reserved
                ent_d[idx] <= hold_d;
                ent_m[idx] <= hold_m;
              end
            end else begin
              hold_d <= ent_d[idx];
              hold_m <= ent_m[idx];
            end
            RAM_ACT:   if (op_q) act_ram[idx] <= act_hold; else act_hold <= act_ram[idx];
            RAM_METER: if (op_q) met_ram[idx] <= met_hold; else met_hold <= met_ram[idx];
            default: ;
          endcase
        end
      end
      if (clr_q) begin
        ent_d[clr_cnt] <= '0;
        ent_m[clr_cnt] <= '0;
        if (clr_cnt == LAST) begin
          clr_q   <= 1'b0;
          clr_cnt <= '0;
        end else begin
          clr_cnt <= clr_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[4:3] == 2'b00) reg_rdata_o = hold_d[reg_addr_i[2:0]];
    else if (reg_addr_i[4:3] == 2'b01) reg_rdata_o = hold_m[reg_addr_i[2:0]];
    else begin
      case (reg_addr_i)
        REG_ACC: reg_rdata_o = {16'b0, addr_q, 3'b0, clr_q, ram_q, op_q, start_q};
        REG_ACT: reg_rdata_o = act_hold;
        REG_MET: reg_rdata_o = met_hold;
        REG_PEN: reg_rdata_o = 32'(pen_q);
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign ent_d_o   = ent_d;
  assign ent_m_o   = ent_m;
  assign act_o     = act_ram;
  assign port_en_o = pen_q;

  a_r7_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  a_r8_clear_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && clr_cnt == LAST) |=> !clr_q);
  a_r10_fields_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && reg_addr_i == REG_ACC) |=> $stable(addr_q));
  a_r6_entry0_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_d[0][0][1:0] == 2'b00);
endmodule

// File: rtl/ctam_match.sv
module ctam_match
  import chain_tcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 go_i,
  input  logic [$clog2(NUM_PORTS)-1:0]         port_i,
  input  logic [KEY_W-1:0]                     key0_i,
  input  logic [KEY_W-1:0]                     key1_i,
  input  ent_t [NUM_ENTRIES-1:0]               ent_d_i,
  input  ent_t [NUM_ENTRIES-1:0]               ent_m_i,
  output logic                                 s1_valid_o,
  output logic [NUM_ENTRIES-1:0]               s1_uhit0_o,
  output logic [NUM_ENTRIES-1:0]               s1_uhit_o,
  output logic [NUM_ENTRIES-1:0]               s1_chit_o,
  output logic [NUM_ENTRIES-1:0][CHAIN_W-1:0]  s1_chain_o
);
  logic [NUM_ENTRIES-1:0] uhit0_c, uhit_c, chit_c;
  logic [NUM_ENTRIES-1:0][CHAIN_W-1:0] chain_c;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [ENTRY_W-1:0] d, m;
    logic [1:0] sl;
    logic vld, chained, sl_ok, body_ok, port_ok, raw;
    logic [KEY_W-1:0] key, cmask;
    logic [NUM_PORTS-1:0] pmap, pmask, pm_and;

    assign d       = ent_d_i[i];
    assign m       = ent_m_i[i];
    assign sl      = d[3:2];
    assign vld     = d[1:0] == 2'b11;
    assign chain_c[i] = d[CHAIN_LSB +: CHAIN_W];
    assign chained = |d[CHAIN_LSB +: CHAIN_W];
    assign sl_ok   = 32'(sl) < NUM_SLICES;
    assign key     = sl[0] ? key1_i : key0_i;
    // control fields of word 0 and the chain field never take part in the compare
    assign cmask   = m[KEY_W-1:0] &
                     ~{{CHAIN_W{chained}}, {(KEY_W-CHAIN_W-4){1'b0}}, 4'hF};
    assign body_ok = ((key ^ d[KEY_W-1:0]) & cmask) == '0;
    assign pmap    = d[PORT_LSB +: NUM_PORTS];
    assign pmask   = m[PORT_LSB +: NUM_PORTS];
    assign pm_and  = pmap & pmask;
    assign port_ok = (pmask == '0) || pm_and[port_i];
    assign raw     = vld && sl_ok && body_ok && port_ok;

    assign uhit0_c[i] = raw && !chained && (sl == 2'd0);
    assign uhit_c[i]  = raw && !chained;
    assign chit_c[i]  = raw && chained;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_o <= 1'b0;
      s1_uhit0_o <= '0;
      s1_uhit_o  <= '0;
      s1_chit_o  <= '0;
      s1_chain_o <= '0;
    end else begin
      s1_valid_o <= go_i;
      s1_uhit0_o <= uhit0_c;
      s1_uhit_o  <= uhit_c;
      s1_chit_o  <= chit_c;
      s1_chain_o <= chain_c;
    end
  end
endmodule

// File: rtl/ctam_resolve.sv
module ctam_resolve
  import chain_tcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 s1_valid_i,
  input  logic [NUM_ENTRIES-1:0]               s1_uhit0_i,
  input  logic [NUM_ENTRIES-1:0]               s1_uhit_i,
  input  logic [NUM_ENTRIES-1:0]               s1_chit_i,
  input  logic [NUM_ENTRIES-1:0][CHAIN_W-1:0]  s1_chain_i,
  input  logic [NUM_ENTRIES-1:0][WORD_W-1:0]   act_i,
  output logic                                 res_valid_o,
  output logic                                 res_hit_o,
  output logic                                 res_miss_o,
  output logic [$clog2(NUM_ENTRIES)-1:0]       res_idx_o,
  output logic [WORD_W-1:0]                    res_action_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  function automatic logic [IDX_W-1:0] lowest(input logic [NUM_ENTRIES-1:0] v);
    lowest = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) if (v[i]) lowest = IDX_W'(i);
  endfunction

  logic h0_v, f_v;
  logic [IDX_W-1:0] h0, f_idx;
  logic [NUM_ENTRIES-1:0] final_hit;

  always_comb begin
    h0_v = |s1_uhit0_i;
    h0   = lowest(s1_uhit0_i);
    for (int i = 0; i < NUM_ENTRIES; i++)
      final_hit[i] = s1_uhit_i[i] |
                     (s1_chit_i[i] & h0_v & (s1_chain_i[i] == CHAIN_W'(h0)));
    f_v   = |final_hit;
    f_idx = lowest(final_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_miss_o   <= 1'b0;
      res_idx_o    <= '0;
      res_action_o <= '0;
    end else begin
      res_valid_o  <= s1_valid_i;
      res_hit_o    <= s1_valid_i & f_v;
      res_miss_o   <= s1_valid_i & ~f_v;
      res_idx_o    <= (s1_valid_i && f_v) ? f_idx : '0;
      res_action_o <= (s1_valid_i && f_v) ? act_i[f_idx] : '0;
    end
  end

  a_r2_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_hit_o ^ res_miss_o));
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_hit_o && !res_miss_o));
  a_r6_no_hit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> (res_idx_o != '0));
endmodule

// File: rtl/chain_tcam.sv
module chain_tcam
  import chain_tcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            reg_we_i,
  input  logic [4:0]                      reg_addr_i,
  input  logic [31:0]                     reg_wdata_i,
  output logic [31:0]                     reg_rdata_o,
  input  logic                            lk_valid_i,
  input  logic [$clog2(NUM_PORTS)-1:0]    lk_port_i,
  input  logic [223:0]                    lk_key0_i,
  input  logic [223:0]                    lk_key1_i,
  output logic                            res_valid_o,
  output logic                            res_hit_o,
  output logic                            res_miss_o,
  output logic [$clog2(NUM_ENTRIES)-1:0]  res_idx_o,
  output logic [31:0]                     res_action_o
);
  ent_t [NUM_ENTRIES-1:0] ent_d, ent_m;
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] act;
  logic [NUM_PORTS-1:0] port_en;
  logic lk_go, s1_valid;
  logic [NUM_ENTRIES-1:0] s1_uhit0, s1_uhit, s1_chit;
  logic [NUM_ENTRIES-1:0][CHAIN_W-1:0] s1_chain;

  assign lk_go = lk_valid_i & port_en[lk_port_i];

  ctam_host #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS)) i_host (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .ent_d_o(ent_d), .ent_m_o(ent_m), .act_o(act), .port_en_o(port_en)
  );

  ctam_match #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS)) i_match (
    .clk_i, .rst_ni, .go_i(lk_go), .port_i(lk_port_i),
    .key0_i(lk_key0_i), .key1_i(lk_key1_i),
    .ent_d_i(ent_d), .ent_m_i(ent_m),
    .s1_valid_o(s1_valid), .s1_uhit0_o(s1_uhit0), .s1_uhit_o(s1_uhit),
    .s1_chit_o(s1_chit), .s1_chain_o(s1_chain)
  );

  ctam_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) i_resolve (
    .clk_i, .rst_ni, .s1_valid_i(s1_valid),
    .s1_uhit0_i(s1_uhit0), .s1_uhit_i(s1_uhit), .s1_chit_i(s1_chit),
    .s1_chain_i(s1_chain), .act_i(act),
    .res_valid_o, .res_hit_o, .res_miss_o, .res_idx_o, .res_action_o
  );

  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(lk_go, 2));
endmodule

// File: tb/test_chain_tcam.sv
`timescale 1ns/1ps
module test_chain_tcam;
  localparam int NE = 16;
  localparam int NP = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [4:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic lk_valid_i = 1'b0;
  logic [2:0] lk_port_i = '0;
  logic [223:0] lk_key0_i = '0, lk_key1_i = '0;
  logic res_valid_o, res_hit_o, res_miss_o;
  logic [3:0] res_idx_o;
  logic [31:0] res_action_o;

  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  chain_tcam #(.NUM_ENTRIES(NE), .NUM_PORTS(NP)) i_chain_tcam (.*);

  // k0 word1, k1 word1, port, expect hit, expect idx
  localparam logic [87:0] VEC [9] = '{
    {32'h1111_2222, 32'h0000_0000, 8'd0, 8'd1, 8'd5},   // R2 two hits, lowest
    {32'h1111_9999, 32'h0000_0000, 8'd0, 8'd1, 8'd5},   // R1 masked low half
    {32'h1112_2222, 32'h0000_0000, 8'd0, 8'd0, 8'd0},   // R1 masked bit differs
    {32'h3333_0001, 32'h4444_4444, 8'd2, 8'd1, 8'd3},   // R5 chain completes
    {32'h3333_0001, 32'h4444_4444, 8'd1, 8'd0, 8'd0},   // R4 port not in map
    {32'h3333_0001, 32'h4444_4445, 8'd2, 8'd1, 8'd9},   // R5 second half fails
    {32'h1111_0000, 32'h4444_4444, 8'd2, 8'd1, 8'd5},   // R5 chain id mismatch
    {32'h0000_0000, 32'h5555_1234, 8'd0, 8'd1, 8'd12},  // R9 slice 1 key
    {32'h0000_0000, 32'h0000_0000, 8'd0, 8'd0, 8'd0}    // R6/R9 entry 0 and slice 2
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic op(input logic [7:0] addr, input logic [1:0] ram, input bit wr_op);
    wr(5'd16, {16'b0, addr, 4'b0, ram, wr_op, 1'b1});
    @(negedge clk_i);
  endtask

  task automatic prog(input int idx, input logic [1:0] sl, input logic [7:0] chain,
                      input logic [31:0] w1, input logic [31:0] m1,
                      input logic [7:0] pmap, input logic [7:0] pmask);
    wr(5'd0, {28'b0, sl, 2'b11});
    wr(5'd1, w1);
    for (int w = 2; w < 6; w++) wr(5'(w), 32'h0);
    wr(5'd6, {chain, 24'h0});
    wr(5'd7, 32'(pmap));
    wr(5'd8, 32'h0);
    wr(5'd9, m1);
    for (int w = 10; w < 15; w++) wr(5'(w), 32'h0);
    wr(5'd15, 32'(pmask));
    op(8'(idx), 2'd0, 1'b1);
    wr(5'd17, 32'hAC00_0000 | 32'(idx));
    op(8'(idx), 2'd1, 1'b1);
  endtask

  task automatic lookup(input logic [31:0] k0, input logic [31:0] k1, input logic [2:0] p,
                        output logic early, output logic v, output logic h, output logic mi,
                        output logic [3:0] ix, output logic [31:0] ac);
    lk_valid_i = 1'b1; lk_port_i = p;
    lk_key0_i = {160'b0, k0, 32'b0};
    lk_key1_i = {160'b0, k1, 32'b0};
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    early = res_valid_o;
    @(negedge clk_i);
    v = res_valid_o; h = res_hit_o; mi = res_miss_o; ix = res_idx_o; ac = res_action_o;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic e, v, h, mi;
    logic [3:0] ix;
    logic [31:0] ac;
    int bad;

    repeat (3) @(negedge clk_i);
    rd(5'd16, r);
    chk(res_valid_o == 1'b0 && r == 32'h0, "R7", "reset state", {31'b0, res_valid_o} | r, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    wr(5'd19, 32'hFF);
    prog(5,  2'd0, 8'd0, 32'h1111_0000, 32'hFFFF_0000, 8'hFF, 8'hFF);
    prog(7,  2'd0, 8'd0, 32'h1111_2222, 32'hFFFF_FFFF, 8'hFF, 8'hFF);
    prog(9,  2'd0, 8'd0, 32'h3333_0000, 32'hFFFF_0000, 8'h04, 8'hFF);
    prog(3,  2'd1, 8'd9, 32'h4444_4444, 32'hFFFF_FFFF, 8'h00, 8'h00);
    prog(12, 2'd1, 8'd0, 32'h5555_0000, 32'hFFFF_0000, 8'h00, 8'h00);
    prog(14, 2'd2, 8'd0, 32'h0000_0000, 32'h0000_0000, 8'h00, 8'h00);
    prog(0,  2'd0, 8'd0, 32'h0000_0000, 32'h0000_0000, 8'h00, 8'h00);

    foreach (VEC[n]) begin
      logic [31:0] exp_act;
      logic exp_hit;
      logic [3:0] exp_idx;
      exp_hit = VEC[n][8];
      exp_idx = VEC[n][3:0];
      exp_act = exp_hit ? (32'hAC00_0000 | 32'(exp_idx)) : 32'h0;
      lookup(VEC[n][87:56], VEC[n][55:24], VEC[n][18:16], e, v, h, mi, ix, ac);
      chk(!e && v, "R3", $sformatf("vec %0d timing", n), {30'b0, e, v}, 32'h1);
      chk(h == exp_hit && mi == !exp_hit, "R2", $sformatf("vec %0d hit/miss", n),
          {30'b0, h, mi}, {30'b0, exp_hit, !exp_hit});
      chk(ix == exp_idx && ac == exp_act, "R2", $sformatf("vec %0d idx/action", n),
          {ix, ac[27:0]}, {exp_idx, exp_act[27:0]});
    end

    // R4 port enable gates lookups
    wr(5'd19, 32'hFE);
    lookup(32'h1111_2222, 32'h0, 3'd0, e, v, h, mi, ix, ac);
    @(negedge clk_i);
    chk(!e && !v && !res_valid_o, "R4", "disabled port result", {31'b0, v | res_valid_o}, 32'h0);
    wr(5'd19, 32'hFF);

    // R7 start bit busy for one cycle, read back
    wr(5'd16, {16'b0, 8'd7, 8'h01});
    rd(5'd16, r);
    chk(r[0] == 1'b1, "R7", "start busy after launch", r, 32'h0701);
    @(negedge clk_i);
    rd(5'd16, r);
    chk(r[0] == 1'b0, "R7", "start self-clears", r, 32'h0700);
    rd(5'd1, r);
    chk(r == 32'h1111_2222, "R7", "table read word1", r, 32'h1111_2222);

    // R7 meter RAM write and read
    wr(5'd18, 32'h0BAD_F00D);
    op(8'd4, 2'd2, 1'b1);
    wr(5'd18, 32'h0);
    op(8'd4, 2'd2, 1'b0);
    rd(5'd18, r);
    chk(r == 32'h0BAD_F00D, "R7", "meter readback", r, 32'h0BAD_F00D);

    // R6 entry 0 untouched
    op(8'd0, 2'd0, 1'b0);
    rd(5'd0, r);
    chk(r == 32'h0, "R6", "entry 0 word0", r, 32'h0);

    // R1 drop valid bits of entry 5
    op(8'd5, 2'd0, 1'b0);
    rd(5'd0, r);
    chk(r == 32'h3, "R1", "entry 5 word0", r, 32'h3);
    wr(5'd0, r & ~32'h3);
    op(8'd5, 2'd0, 1'b1);
    lookup(32'h1111_2222, 32'h0, 3'd0, e, v, h, mi, ix, ac);
    chk(v && h && ix == 4'd7, "R1", "invalidated entry skipped", 32'(ix), 32'h7);

    // R10 access write while busy is dropped
    wr(5'd16, {16'b0, 8'd15, 8'h03});
    wr(5'd16, {16'b0, 8'd7, 8'h01});
    rd(5'd16, r);
    chk(r[15:8] == 8'd15 && r[1] == 1'b1, "R10", "fields kept while busy", r, 32'h0F02);

    // R8 clear
    wr(5'd16, 32'h10);
    bad = 0;
    for (int k = 0; k < NE; k++) begin
      rd(5'd16, r);
      if (r[4] !== 1'b1) bad++;
      @(negedge clk_i);
    end
    rd(5'd16, r);
    chk(bad == 0 && r[4] == 1'b0, "R8", "clear bit duration", {r[15:0], 16'(bad)}, 32'h0);
    lookup(32'h1111_2222, 32'h0, 3'd0, e, v, h, mi, ix, ac);
    chk(v && mi && !h, "R8", "table empty after clear", {30'b0, h, mi}, 32'h1);
    lookup(32'h3333_0001, 32'h4444_4444, 3'd2, e, v, h, mi, ix, ac);
    chk(v && mi && !h, "R5", "chain gone after clear", {30'b0, h, mi}, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule